// File: doc/BRIEF.md
# MSI Doorbell to Interrupt Frame

This block is a small memory-mapped register frame that sits between a bus master and a bank of interrupt lines. A device raises a message-signalled interrupt by writing an absolute interrupt ID into the frame's doorbell register. The frame subtracts the first ID it owns, checks that the result falls inside its window, and pulses the matching local line high for one clock cycle. Writes whose ID falls outside the window are dropped without any error.

Software can discover the window by reading a type register. That register returns the first owned ID, which is the base parameter plus 32, and the number of lines. A fixed interface identification word and a block of identification offsets that read as zero are also decoded. The frame spans a 4 KB little-endian window. Any access at an offset it does not decode, or any access of an illegal size, returns zero or has no effect, and raises a one-cycle error flag.

The base and the line count are parameters. Elaboration stops with an error if there are more than 128 lines, or if the first ID plus the line count exceeds 1020.

Top module: `msi_doorbell_frame`

## Requirements
- R1: A 4-byte read of offset 0x008 returns ((BASE_ID + 32) << 16) | NUM_LINES, with no error flag.
- R2: A 4-byte read of offset 0xFCC returns 0x05100000 (product code 0x51 in bits 27:20, all other fields zero), with no error flag.
- R3: A 4-byte read of any offset from 0xFD0 through 0xFFC returns zero, with no error flag.
- R4: A 2- or 4-byte write to offset 0x040 whose data bits 9:0 hold an ID in [BASE_ID+32, BASE_ID+32+NUM_LINES) drives irq_pulse bit (ID - BASE_ID - 32) high for exactly the one cycle after the write edge. All other bits stay low.
- R5: A doorbell write whose ID in bits 9:0 falls outside that window produces no pulse and no error flag. Data bits 31:10 are ignored.
- R6: Doorbell writes to the same ID on consecutive cycles produce pulses on consecutive cycles, and the line falls in the cycle after the last one.
- R7: A read whose bus_size (byte count: 1, 2 or 4) is not 4 returns zero and raises bad_access for one cycle.
- R8: A write whose bus_size is neither 2 nor 4 is discarded (no pulse) and raises bad_access for one cycle. A 2-byte doorbell write is accepted.
- R9: A read or write of an offset the frame does not decode returns zero or has no effect, and raises bad_access for one cycle. This covers a read of 0x040, a write to 0x008 and an access to an unused offset.
- R10: Read data appears on bus_rdata in the cycle after the read edge. In a cycle that follows no accepted read, bus_rdata is zero.
- R11: While rst is high, and in the first cycle after it, irq_pulse, bad_access and bus_rdata are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset within the frame |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_size | input | 3 | Access size in bytes (1, 2 or 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bad_access | output | 1 | One-cycle flag for a bad offset or size |
| irq_pulse | output | NUM_LINES | One-cycle interrupt pulses, one per line |

## Verification
The bench builds the frame with BASE_ID = 16 and NUM_LINES = 8. This places the owned IDs at 48 through 55. With only eight lines, both window edges (IDs 47, 48, 55 and 56) sit next to a small, fully observable output bank, so every pulse pattern can be compared whole. The non-zero base also makes the type register read 0x00300008, which shows that both fields are placed correctly. It also shows that the ID subtraction uses the offset base rather than zero.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;

    localparam int ADDR_W      = 12;
    localparam int DATA_W      = 32;
    localparam int ID_W        = 10;
    localparam int ID_OFFSET   = 32;
    localparam int ID_LIMIT    = 1020;
    localparam int MAX_LINES   = 128;

    localparam logic [ADDR_W-1:0] OFS_TYPE      = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_DOORBELL  = 12'h040;
    localparam logic [ADDR_W-1:0] OFS_IFACE_ID  = 12'hFCC;
    localparam logic [ADDR_W-1:0] OFS_IDBLK_LO  = 12'hFD0;
    localparam logic [ADDR_W-1:0] OFS_IDBLK_HI  = 12'hFFC;

    localparam logic [7:0] PRODUCT_CODE = 8'h51;
    localparam int         PRODUCT_LSB  = 20;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_TYPE,
        RG_DOORBELL,
        RG_IFACE_ID,
        RG_ID_BLOCK
    } region_e;

    typedef struct packed {
        region_e region;
        logic    rd_accept;
        logic    wr_fire;
        logic    bad;
    } access_t;

    function automatic region_e decode_region(input logic [ADDR_W-1:0] addr);
        region_e r;
        r = RG_NONE;
        if (addr == OFS_TYPE)
            r = RG_TYPE;
        else if (addr == OFS_DOORBELL)
            r = RG_DOORBELL;
        else if (addr == OFS_IFACE_ID)
            r = RG_IFACE_ID;
        else if (addr >= OFS_IDBLK_LO && addr <= OFS_IDBLK_HI)
            r = RG_ID_BLOCK;
        return r;
    endfunction

    function automatic logic read_size_ok(input logic [2:0] size);
        return size == 3'd4;
    endfunction

    function automatic logic write_size_ok(input logic [2:0] size);
        return (size == 3'd2) || (size == 3'd4);
    endfunction

endpackage

// File: rtl/msi_frame_decode.sv
module msi_frame_decode
    import msi_frame_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [2:0]        size,
    output access_t           acc
);

    region_e region;
    logic    readable;

    always_comb begin
        region   = decode_region(addr);
        readable = (region == RG_TYPE) || (region == RG_IFACE_ID) ||
                   (region == RG_ID_BLOCK);
        acc.region    = region;
        acc.rd_accept = rd && readable && read_size_ok(size);
        acc.wr_fire   = wr && (region == RG_DOORBELL) && write_size_ok(size);
        acc.bad       = (rd && !acc.rd_accept) || (wr && !acc.wr_fire);
    end

endmodule

// File: rtl/msi_doorbell_pulse.sv
module msi_doorbell_pulse
    import msi_frame_pkg::*;
#(
    parameter int BASE_ID   = 0,
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fire,
    input  logic [ID_W-1:0]      id,
    output logic [NUM_LINES-1:0] pulse
);

    localparam int FIRST_ID = BASE_ID + ID_OFFSET;
    localparam int END_ID   = FIRST_ID + NUM_LINES;
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    logic [ID_W:0]   id_ext;
    logic            in_window;
    logic [ID_W:0]   offset_full;
    logic [IDX_W-1:0] local_idx;

    always_comb begin
        id_ext      = {1'b0, id};
        in_window   = (id_ext >= (ID_W+1)'(FIRST_ID)) &&
                      (id_ext <  (ID_W+1)'(END_ID));
        offset_full = id_ext - (ID_W+1)'(FIRST_ID);
        local_idx   = offset_full[IDX_W-1:0];
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)
                pulse[i] <= 1'b0;
            else
                pulse[i] <= fire && in_window && (local_idx == IDX_W'(i));
        end
    end

endmodule

// File: rtl/msi_frame_readback.sv
module msi_frame_readback
    import msi_frame_pkg::*;
#(
    parameter int BASE_ID   = 0,
    parameter int NUM_LINES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_accept,
    input  region_e           region,
    output logic [DATA_W-1:0] rdata
);

    localparam int FIRST_ID = BASE_ID + ID_OFFSET;
    localparam logic [DATA_W-1:0] TYPE_WORD =
        (DATA_W'(FIRST_ID) << 16) | DATA_W'(NUM_LINES);
    localparam logic [DATA_W-1:0] IFACE_WORD =
        DATA_W'(PRODUCT_CODE) << PRODUCT_LSB;

    logic [DATA_W-1:0] next_word;

    always_comb begin
        case (region)
            RG_TYPE:     next_word = TYPE_WORD;
            RG_IFACE_ID: next_word = IFACE_WORD;
            default:     next_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else
            rdata <= rd_accept ? next_word : '0;
    end

endmodule

// File: rtl/msi_doorbell_frame.sv
module msi_doorbell_frame
    import msi_frame_pkg::*;
#(
    parameter int BASE_ID   = 0,
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [11:0]          bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [2:0]           bus_size,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic                 bad_access,
    output logic [NUM_LINES-1:0] irq_pulse
);

    if (NUM_LINES < 1 || NUM_LINES > MAX_LINES) begin : g_bad_count
        $error("msi_doorbell_frame: line count out of range");
    end
    if (BASE_ID < 0 || BASE_ID + ID_OFFSET + NUM_LINES > ID_LIMIT) begin : g_bad_base
        $error("msi_doorbell_frame: interrupt ID window exceeds limit");
    end

    access_t acc;
    logic    unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[31:ID_W];

    msi_frame_decode u_decode (
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .size (bus_size),
        .acc  (acc)
    );

    msi_doorbell_pulse #(
        .BASE_ID   (BASE_ID),
        .NUM_LINES (NUM_LINES)
    ) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .fire  (acc.wr_fire),
        .id    (bus_wdata[ID_W-1:0]),
        .pulse (irq_pulse)
    );

    msi_frame_readback #(
        .BASE_ID   (BASE_ID),
        .NUM_LINES (NUM_LINES)
    ) u_readback (
        .clk       (clk),
        .rst       (rst),
        .rd_accept (acc.rd_accept),
        .region    (acc.region),
        .rdata     (bus_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst)
            bad_access <= 1'b0;
        else
            bad_access <= acc.bad;
    end

endmodule

// File: rtl/msi_frame_checker.sv
module msi_frame_checker #(
    parameter int NUM_LINES = 64
) (
    input logic                 clk,
    input logic                 rst,
    input logic [11:0]          bus_addr,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [2:0]           bus_size,
    input logic [31:0]          bus_rdata,
    input logic                 bad_access,
    input logic [NUM_LINES-1:0] irq_pulse
);

    AST_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_pulse)); // R4

    AST_PULSE_FROM_DOORBELL: assert property (@(posedge clk) disable iff (rst)
        (|irq_pulse) |-> $past(bus_wr && bus_addr == 12'h040 &&
                               (bus_size == 3'd2 || bus_size == 3'd4))); // R8

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> (irq_pulse == '0)); // R6

    AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == '0)); // R10

    AST_RD_BAD_SIZE: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_size != 3'd4) |=> (bad_access && bus_rdata == '0)); // R7

    AST_WR_BAD_SIZE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_size != 3'd2 && bus_size != 3'd4)
            |=> (bad_access && irq_pulse == '0)); // R8

    AST_BAD_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (rst)
        bad_access |-> $past(bus_rd || bus_wr)); // R9

endmodule

bind msi_doorbell_frame msi_frame_checker #(.NUM_LINES(NUM_LINES)) u_chk (.*);

// File: tb/tb_msi_doorbell_frame.sv
`timescale 1ns/1ps
module tb_msi_doorbell_frame;

    localparam int BASE_ID = 16;
    localparam int NL      = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [11:0]   bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [2:0]    bus_size = 3'd4;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bad_access;
    logic [NL-1:0] irq_pulse;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #2 clk = ~clk;

    msi_doorbell_frame #(.BASE_ID(BASE_ID), .NUM_LINES(NL)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bad_access(bad_access), .irq_pulse(irq_pulse)
    );

    typedef struct packed {
        logic        is_wr;
        logic [11:0] addr;
        logic [2:0]  size;
        logic [31:0] wdata;
        logic [31:0] exp_rdata;
        logic        exp_bad;
        logic [7:0]  exp_pulse;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h008, 3'd4, 32'h0, 32'h0030_0008, 1'b0, 8'h00, 4'd1},  // R1
        '{1'b0, 12'hFCC, 3'd4, 32'h0, 32'h0510_0000, 1'b0, 8'h00, 4'd2},  // R2
        '{1'b0, 12'hFD0, 3'd4, 32'h0, 32'h0,         1'b0, 8'h00, 4'd3},  // R3
        '{1'b0, 12'hFFC, 3'd4, 32'h0, 32'h0,         1'b0, 8'h00, 4'd3},  // R3
        '{1'b0, 12'hFE4, 3'd4, 32'h0, 32'h0,         1'b0, 8'h00, 4'd3},  // R3
        '{1'b1, 12'h040, 3'd4, 32'd48, 32'h0,        1'b0, 8'h01, 4'd4},  // R4
        '{1'b1, 12'h040, 3'd4, 32'd55, 32'h0,        1'b0, 8'h80, 4'd4},  // R4
        '{1'b1, 12'h040, 3'd4, 32'd51, 32'h0,        1'b0, 8'h08, 4'd4},  // R4
        '{1'b1, 12'h040, 3'd2, 32'd50, 32'h0,        1'b0, 8'h04, 4'd8},  // R8
        '{1'b1, 12'h040, 3'd4, 32'd47, 32'h0,        1'b0, 8'h00, 4'd5},  // R5
        '{1'b1, 12'h040, 3'd4, 32'd56, 32'h0,        1'b0, 8'h00, 4'd5},  // R5
        '{1'b1, 12'h040, 3'd4, 32'hFFFF_FC31, 32'h0, 1'b0, 8'h02, 4'd5},  // R5
        '{1'b0, 12'h008, 3'd2, 32'h0, 32'h0,         1'b1, 8'h00, 4'd7},  // R7
        '{1'b0, 12'hFCC, 3'd1, 32'h0, 32'h0,         1'b1, 8'h00, 4'd7},  // R7
        '{1'b1, 12'h040, 3'd1, 32'd48, 32'h0,        1'b1, 8'h00, 4'd8},  // R8
        '{1'b1, 12'h040, 3'd3, 32'd49, 32'h0,        1'b1, 8'h00, 4'd8},  // R8
        '{1'b0, 12'h040, 3'd4, 32'h0, 32'h0,         1'b1, 8'h00, 4'd9},  // R9
        '{1'b1, 12'h008, 3'd4, 32'd48, 32'h0,        1'b1, 8'h00, 4'd9},  // R9
        '{1'b0, 12'h100, 3'd4, 32'h0, 32'h0,         1'b1, 8'h00, 4'd9}   // R9
    };

    task automatic check(input string tag, input logic [31:0] rd_exp,
                         input logic bad_exp, input logic [7:0] p_exp);
        n_tests++;
        if (bus_rdata !== rd_exp || bad_access !== bad_exp || irq_pulse !== p_exp) begin
            n_fail++;
            $display("FAIL %s: rdata=%h bad=%b pulse=%h expected rdata=%h bad=%b pulse=%h",
                     tag, bus_rdata, bad_access, irq_pulse, rd_exp, bad_exp, p_exp);
        end
    endtask

    task automatic idle_inputs();
        bus_wr = 1'b0;
        bus_rd = 1'b0;
        bus_addr = '0;
        bus_size = 3'd4;
        bus_wdata = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R11: outputs during and just after reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 in reset", 32'h0, 1'b0, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        check("R11 after reset", 32'h0, 1'b0, 8'h00);

        for (int v = 0; v < NV; v++) begin
            string tag;
            @(negedge clk);
            bus_wr    = VECS[v].is_wr;
            bus_rd    = !VECS[v].is_wr;
            bus_addr  = VECS[v].addr;
            bus_size  = VECS[v].size;
            bus_wdata = VECS[v].wdata;
            @(negedge clk);
            idle_inputs();
            tag = $sformatf("R%0d vector %0d", VECS[v].req, v);
            check(tag, VECS[v].exp_rdata, VECS[v].exp_bad, VECS[v].exp_pulse);
            @(negedge clk);
            // R10: data and flags clear in the cycle after an idle edge
            check("R10 idle after vector", 32'h0, 1'b0, 8'h00);
        end

        // R6: back-to-back doorbell writes to ID 52
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h040; bus_size = 3'd4; bus_wdata = 32'd52;
        @(negedge clk);
        check("R6 first pulse", 32'h0, 1'b0, 8'h10);
        @(negedge clk);
        idle_inputs();
        check("R6 second pulse", 32'h0, 1'b0, 8'h10);
        @(negedge clk);
        check("R6 pulse ends", 32'h0, 1'b0, 8'h00);

        // R10: consecutive reads, each result one cycle after its edge
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 12'h008; bus_size = 3'd4;
        @(negedge clk);
        bus_addr = 12'hFCC;
        check("R10 first read", 32'h0030_0008, 1'b0, 8'h00);
        @(negedge clk);
        idle_inputs();
        check("R10 second read", 32'h0510_0000, 1'b0, 8'h00);
        @(negedge clk);
        check("R10 read data clears", 32'h0, 1'b0, 8'h00);

        // R4/R9: bad access followed by good doorbell, flag lasts one cycle
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h044; bus_size = 3'd4; bus_wdata = 32'd53;
        @(negedge clk);
        bus_addr = 12'h040;
        check("R9 unused write offset", 32'h0, 1'b1, 8'h00);
        @(negedge clk);
        idle_inputs();
        check("R4 pulse after bad access", 32'h0, 1'b0, 8'h20);

        // R11: reset asserted mid-run clears a pending pulse
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 12'h040; bus_size = 3'd4; bus_wdata = 32'd54;
        rst = 1'b1;
        @(negedge clk);
        idle_inputs();
        check("R11 reset masks doorbell", 32'h0, 1'b0, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        check("R11 after second reset", 32'h0, 1'b0, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule